// File: doc/BRIEF.md
# Clock Ratio Transition Sequencer

This block moves a processor core clock from one divide ratio to another. While it does so, it keeps the refresh settings of the attached DRAM controller valid. A requester presents a target ratio code with a one-cycle valid strobe. The block reads the current ratio from the clock mode register and decides whether the change runs as one step or as two steps through divide-by-2. Each step is a short list of register operations, which the block then carries out in order. The operations are a divider write, a refresh-count update and a self-refresh enable change. Their order depends on the direction of the change.

After every divider write the block holds off for a lock interval. When the clock slows down while self-refresh is off, it also waits after the refresh-count update until both the old count and the new count have run out. Memory-control updates are read-modify-write: the block copies the register's read value and changes only the field it owns. The refresh count for each ratio comes from a table computed at elaboration from the base clock frequency. The block runs on the undivided base clock, so every wait is counted in base-clock cycles.

Top module: `ratio_shift_seq`

## Requirements
- R1: Ratio codes are 3 bits: divide-by-1 = 000, divide-by-2 = 001, divide-by-4 = 011, divide-by-6 = 010, divide-by-8 = 100. Every divider write carries one of these codes.
- R2: A 2→1 step clears self-refresh enable (memory-control bit 16), then writes divider 000, then updates the refresh count.
- R3: A 1→2 step updates the refresh count, then writes divider 001, then sets self-refresh enable.
- R4: A change from 1 to 4, 6 or 8, and a change from 4, 6 or 8 to 1, runs as two steps: first to divide-by-2, then to the target.
- R5: Any other step that raises the divisor updates the count before the divider write. Any other step that lowers it writes the divider first and updates the count after.
- R6: The refresh count goes to memory-control bits 14:8 and equals floor(BASE_MHZ*78/(640*divisor)), limited to 127. Every other memory-control bit keeps its read value.
- R7: After a divider write, the next register write comes exactly LOCK_CYC+1 cycles later, and no write occurs in between.
- R8: If a step raises the divisor while self-refresh is clear, the write that follows the count update comes 64*(old count + new count)*old divisor + 1 cycles after it. Otherwise it comes one cycle later.
- R9: A request whose target equals the current ratio pulses done on the next cycle. Busy stays low and no register is written.
- R10: An undefined code in the request or in the mode register read value pulses err together with done on the next cycle, and no register is written.
- R11: Busy is high from the cycle after an accepted multi-write request until the sequence ends. Done is a one-cycle pulse, seen only while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe, taken while idle |
| req_ratio_i | input | 3 | Target ratio code |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle undefined-code pulse |
| mode_rd_i | input | 3 | Current divider field of the mode register |
| mode_wr_o | output | 1 | Divider field write strobe |
| mode_wr_data_o | output | 3 | Divider field write value |
| mctl_rd_i | input | MCTL_W | Memory-control register read value |
| mctl_wr_o | output | 1 | Memory-control write strobe |
| mctl_wr_data_o | output | MCTL_W | Memory-control write value |

## Verification
The bench builds the block with BASE_MHZ=100 and the default LOCK_CYC=16. With these values the five refresh counts come out small and distinct (12, 6, 3, 2, 1), so every count write can be identified in the write log. The 1→2 drain wait becomes 1152 cycles, short enough to measure exactly inside one run. It also lets the two-step routes 1→8 and 6→1 be followed write by write, together with their gaps.

// File: rtl/rss_pkg.sv
package rss_pkg;

    localparam int CODE_W   = 3;
    localparam int CNT_LSB  = 8;
    localparam int CNT_W    = 7;
    localparam int SREF_BIT = 16;

    localparam logic [CODE_W-1:0] RATIO_1 = 3'b000;
    localparam logic [CODE_W-1:0] RATIO_2 = 3'b001;
    localparam logic [CODE_W-1:0] RATIO_4 = 3'b011;
    localparam logic [CODE_W-1:0] RATIO_6 = 3'b010;
    localparam logic [CODE_W-1:0] RATIO_8 = 3'b100;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SREF_CLR,
        OP_SREF_SET,
        OP_DIV,
        OP_CNT
    } op_e;

    typedef struct packed {
        op_e op0;
        op_e op1;
        op_e op2;
    } plan_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_OP,
        S_WAIT
    } state_e;

    // Divisor of a ratio code; 0 marks an undefined code.
    function automatic logic [3:0] code_div(logic [CODE_W-1:0] c);
        case (c)
            RATIO_1: return 4'd1;
            RATIO_2: return 4'd2;
            RATIO_4: return 4'd4;
            RATIO_6: return 4'd6;
            RATIO_8: return 4'd8;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic code_ok(logic [CODE_W-1:0] c);
        return code_div(c) != 4'd0;
    endfunction

    // 64-cycle units in 7.8 us at base_mhz/div.
    function automatic logic [CNT_W-1:0] refresh_units(int unsigned base_mhz, int unsigned div);
        int unsigned v;
        v = (base_mhz * 78) / (640 * div);
        if (v > 127) v = 127;
        return v[CNT_W-1:0];
    endfunction

    function automatic op_e op_at(plan_t p, logic [1:0] idx);
        case (idx)
            2'd0:    return p.op0;
            2'd1:    return p.op1;
            2'd2:    return p.op2;
            default: return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rss_step_plan.sv
module rss_step_plan
    import rss_pkg::*;
(
    input  logic [CODE_W-1:0] from_code_i,
    input  logic [CODE_W-1:0] to_code_i,
    output plan_t             plan_o,
    output logic              slowing_o
);
    logic [3:0] fd;
    logic [3:0] td;

    always_comb begin
        fd        = code_div(from_code_i);
        td        = code_div(to_code_i);
        slowing_o = td > fd;
        plan_o.op2 = OP_NONE;
        if (fd == 4'd2 && td == 4'd1) begin
            plan_o.op0 = OP_SREF_CLR;
            plan_o.op1 = OP_DIV;
            plan_o.op2 = OP_CNT;
        end else if (fd == 4'd1 && td == 4'd2) begin
            plan_o.op0 = OP_CNT;
            plan_o.op1 = OP_DIV;
            plan_o.op2 = OP_SREF_SET;
        end else if (td > fd) begin
            plan_o.op0 = OP_CNT;
            plan_o.op1 = OP_DIV;
        end else begin
            plan_o.op0 = OP_DIV;
            plan_o.op1 = OP_CNT;
        end
    end
endmodule

// File: rtl/rss_refresh_rom.sv
module rss_refresh_rom
    import rss_pkg::*;
#(
    parameter int unsigned BASE_MHZ = 500
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam int N_CODES = 1 << CODE_W;

    logic [CNT_W-1:0] rom [N_CODES];

    for (genvar c = 0; c < N_CODES; c++) begin : g_ent
        localparam logic [3:0] DV = code_div(CODE_W'(c));
        if (DV == 4'd0) begin : g_undef
            assign rom[c] = '0;
        end else begin : g_def
            assign rom[c] = refresh_units(BASE_MHZ, 32'(DV));
        end
    end

    assign cnt_o = rom[code_i];
endmodule

// File: rtl/rss_wait_timer.sv
module rss_wait_timer #(
    parameter int WAIT_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] load_val_i,
    output logic              last_o
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load_i)        cnt_q <= load_val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign last_o = (cnt_q == WAIT_W'(1));
endmodule

// File: rtl/ratio_shift_seq.sv
module ratio_shift_seq
    import rss_pkg::*;
#(
    parameter int unsigned BASE_MHZ     = 500,
    parameter int          LOCK_CYC     = 16,
    parameter int          REFRESH_UNIT = 64,
    parameter int          WAIT_W       = 20,
    parameter int          MCTL_W       = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [2:0]        req_ratio_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    input  logic [2:0]        mode_rd_i,
    output logic              mode_wr_o,
    output logic [2:0]        mode_wr_data_o,
    input  logic [MCTL_W-1:0] mctl_rd_i,
    output logic              mctl_wr_o,
    output logic [MCTL_W-1:0] mctl_wr_data_o
);
    state_e           state_q;
    logic [2:0]       step_from_q, step_to_q, final_to_q;
    logic             two_step_q;
    logic [1:0]       op_idx_q;
    logic             done_q, err_q;

    plan_t            plan;
    logic             slowing;
    logic [CNT_W-1:0] new_cnt, old_cnt;
    op_e              cur_op, next_op;
    logic             step_end, need_drain, tmr_load, tmr_last, advance;
    logic [WAIT_W-1:0] drain_len, tmr_val;
    logic             req_bad, req_same, req_split;

    rss_step_plan u_plan (
        .from_code_i (step_from_q),
        .to_code_i   (step_to_q),
        .plan_o      (plan),
        .slowing_o   (slowing)
    );

    rss_refresh_rom #(.BASE_MHZ(BASE_MHZ)) u_rom (
        .code_i (step_to_q),
        .cnt_o  (new_cnt)
    );

    rss_wait_timer #(.WAIT_W(WAIT_W)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .last_o     (tmr_last)
    );

    always_comb begin
        cur_op    = op_at(plan, op_idx_q);
        next_op   = (op_idx_q == 2'd2) ? OP_NONE : op_at(plan, op_idx_q + 2'd1);
        step_end  = (next_op == OP_NONE);
        old_cnt   = mctl_rd_i[CNT_LSB +: CNT_W];
        drain_len = WAIT_W'(REFRESH_UNIT) * (WAIT_W'(old_cnt) + WAIT_W'(new_cnt))
                    * WAIT_W'(code_div(step_from_q));
        need_drain = slowing && !mctl_rd_i[SREF_BIT] && (drain_len != '0);
        tmr_load  = (state_q == S_OP) &&
                    ((cur_op == OP_DIV) || ((cur_op == OP_CNT) && need_drain));
        tmr_val   = (cur_op == OP_DIV) ? WAIT_W'(LOCK_CYC) : drain_len;
        advance   = ((state_q == S_OP) && !tmr_load) || ((state_q == S_WAIT) && tmr_last);

        mode_wr_o      = (state_q == S_OP) && (cur_op == OP_DIV);
        mode_wr_data_o = step_to_q;
        mctl_wr_o      = (state_q == S_OP) &&
                         ((cur_op == OP_CNT) || (cur_op == OP_SREF_CLR) || (cur_op == OP_SREF_SET));
        mctl_wr_data_o = mctl_rd_i;
        case (cur_op)
            OP_CNT:      mctl_wr_data_o[CNT_LSB +: CNT_W] = new_cnt;
            OP_SREF_CLR: mctl_wr_data_o[SREF_BIT] = 1'b0;
            OP_SREF_SET: mctl_wr_data_o[SREF_BIT] = 1'b1;
            default: ;
        endcase

        req_bad   = !code_ok(req_ratio_i) || !code_ok(mode_rd_i);
        req_same  = (req_ratio_i == mode_rd_i);
        req_split = ((mode_rd_i == RATIO_1) && (code_div(req_ratio_i) > 4'd2)) ||
                    ((code_div(mode_rd_i) > 4'd2) && (req_ratio_i == RATIO_1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            step_from_q <= RATIO_1;
            step_to_q   <= RATIO_1;
            final_to_q  <= RATIO_1;
            two_step_q  <= 1'b0;
            op_idx_q    <= 2'd0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (req_valid_i) begin
                        if (req_bad) begin
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                        end else if (req_same) begin
                            done_q <= 1'b1;
                        end else begin
                            step_from_q <= mode_rd_i;
                            step_to_q   <= req_split ? RATIO_2 : req_ratio_i;
                            final_to_q  <= req_ratio_i;
                            two_step_q  <= req_split;
                            op_idx_q    <= 2'd0;
                            state_q     <= S_OP;
                        end
                    end
                end
                default: begin
                    if (tmr_load) state_q <= S_WAIT;
                    if (advance) begin
                        if (!step_end) begin
                            op_idx_q <= op_idx_q + 2'd1;
                            state_q  <= S_OP;
                        end else if (two_step_q) begin
                            step_from_q <= step_to_q;
                            step_to_q   <= final_to_q;
                            two_step_q  <= 1'b0;
                            op_idx_q    <= 2'd0;
                            state_q     <= S_OP;
                        end else begin
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    assign busy_o = (state_q != S_IDLE);
    assign done_o = done_q;
    assign err_o  = err_q;

    // R1
    div_code_chk: assert property (@(posedge clk) disable iff (rst)
        mode_wr_o |-> code_ok(mode_wr_data_o));
    // R7
    lock_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mode_wr_o |=> !mode_wr_o && !mctl_wr_o);
    // R6
    mctl_keep_chk: assert property (@(posedge clk) disable iff (rst)
        mctl_wr_o |-> (mctl_wr_data_o[CNT_LSB-1:0] == mctl_rd_i[CNT_LSB-1:0]) &&
                      (mctl_wr_data_o[CNT_LSB+CNT_W] == mctl_rd_i[CNT_LSB+CNT_W]));
    // R2
    sref_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_wr_o && mode_wr_data_o == RATIO_1) |-> !mctl_rd_i[SREF_BIT]);
    // R10
    err_done_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);
    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
endmodule

// File: tb/ratio_shift_seq_tb.sv
module ratio_shift_seq_tb;
    localparam int MCTL_W = 17;
    localparam int BASE   = 100;
    localparam int LOCK   = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [2:0] req_ratio = 3'b000;
    logic busy, done, err;
    logic mode_wr, mctl_wr;
    logic [2:0] mode_wr_data;
    logic [MCTL_W-1:0] mctl_wr_data;

    logic [2:0] mode_reg;
    logic [MCTL_W-1:0] mctl_reg;
    logic poke = 1'b0;
    logic [2:0] poke_val = 3'b000;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int ev_n = 0;
    int ev_kind [64];
    int ev_data [64];
    int ev_cyc  [64];

    always #10 clk = ~clk;

    ratio_shift_seq #(.BASE_MHZ(BASE), .LOCK_CYC(LOCK)) u_dut (
        .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_ratio_i(req_ratio),
        .busy_o(busy), .done_o(done), .err_o(err),
        .mode_rd_i(mode_reg), .mode_wr_o(mode_wr), .mode_wr_data_o(mode_wr_data),
        .mctl_rd_i(mctl_reg), .mctl_wr_o(mctl_wr), .mctl_wr_data_o(mctl_wr_data)
    );

    // register models
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            mode_reg <= 3'b000;
            mctl_reg <= 17'h00CA5;
        end else begin
            if (poke) mode_reg <= poke_val;
            else if (mode_wr) mode_reg <= mode_wr_data;
            if (mctl_wr) mctl_reg <= mctl_wr_data;
        end
    end

    always @(negedge clk) begin
        if (!rst && ev_n < 64) begin
            if (mode_wr) begin
                ev_kind[ev_n] = 0; ev_data[ev_n] = int'(mode_wr_data); ev_cyc[ev_n] = cyc; ev_n++;
            end
            if (mctl_wr) begin
                ev_kind[ev_n] = 1; ev_data[ev_n] = int'(mctl_wr_data); ev_cyc[ev_n] = cyc; ev_n++;
            end
        end
    end

    function automatic int ref_cnt(int d);
        int v;
        v = (BASE * 78) / (640 * d);
        return (v > 127) ? 127 : v;
    endfunction

    function automatic int mval(int sr, int d);
        return (sr << 16) | (ref_cnt(d) << 8) | 'hA5;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // expected event idx relative to base; gap 0 = not checked
    task automatic exp_ev(string req, int base, int k, int kind, int data, int gap);
        chk({req, " kind"}, ev_kind[base+k], kind);
        chk({req, " data"}, ev_data[base+k], data);
        if (gap > 0) chk({req, " gap"}, ev_cyc[base+k] - ev_cyc[base+k-1], gap);
    endtask

    int busy_seen;
    int done_cnt;
    int err_seen;

    task automatic run_req(logic [2:0] code);
        int guard;
        busy_seen = 0; done_cnt = 0; err_seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_ratio = code;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 20000) begin
            if (busy) busy_seen++;
            @(negedge clk);
            guard++;
        end
        if (done) begin
            done_cnt = 1;
            if (err) err_seen = 1;
        end
        @(negedge clk);
        if (done) done_cnt++;
    endtask

    task automatic t_up_1_2();
        int b = ev_n;
        run_req(3'b001);
        chk("R11 done pulse", done_cnt, 1);
        chk("R11 busy seen", int'(busy_seen > 0), 1);
        chk("R3 writes", ev_n - b, 3);
        exp_ev("R3 R6 count first", b, 0, 1, mval(0, 2), 0);
        exp_ev("R3 R8 drain then div", b, 1, 0, 1, 1 + 64 * (ref_cnt(1) + ref_cnt(2)) * 1);
        exp_ev("R3 R7 sref set", b, 2, 1, mval(1, 2), LOCK + 1);
        chk("R1 mode reg", int'(mode_reg), 1);
    endtask

    task automatic t_down_2_1();
        int b = ev_n;
        run_req(3'b000);
        chk("R2 writes", ev_n - b, 3);
        exp_ev("R2 sref clr", b, 0, 1, mval(0, 2), 0);
        exp_ev("R2 div", b, 1, 0, 0, 1);
        exp_ev("R2 R7 count", b, 2, 1, mval(0, 1), LOCK + 1);
    endtask

    task automatic t_split_1_8();
        int b = ev_n;
        run_req(3'b100);
        chk("R4 writes", ev_n - b, 5);
        exp_ev("R4 s1 count", b, 0, 1, mval(0, 2), 0);
        exp_ev("R4 R8 s1 div", b, 1, 0, 1, 1 + 64 * (ref_cnt(1) + ref_cnt(2)));
        exp_ev("R4 s1 sref", b, 2, 1, mval(1, 2), LOCK + 1);
        exp_ev("R5 R8 s2 count no drain", b, 3, 1, mval(1, 8), 1);
        exp_ev("R5 s2 div", b, 4, 0, 4, 1);
        chk("R1 mode reg div8", int'(mode_reg), 4);
    endtask

    task automatic t_down_8_6();
        int b = ev_n;
        run_req(3'b010);
        chk("R5 writes", ev_n - b, 2);
        exp_ev("R5 div first", b, 0, 0, 2, 0);
        exp_ev("R5 R7 count after", b, 1, 1, mval(1, 6), LOCK + 1);
    endtask

    task automatic t_split_6_1();
        int b = ev_n;
        run_req(3'b000);
        chk("R4 writes back", ev_n - b, 5);
        exp_ev("R4 s1 div", b, 0, 0, 1, 0);
        exp_ev("R4 s1 count", b, 1, 1, mval(1, 2), LOCK + 1);
        exp_ev("R4 R2 s2 sref clr", b, 2, 1, mval(0, 2), 1);
        exp_ev("R4 R2 s2 div", b, 3, 0, 0, 1);
        exp_ev("R4 R2 s2 count", b, 4, 1, mval(0, 1), LOCK + 1);
    endtask

    task automatic t_same();
        int b = ev_n;
        run_req(3'b000);
        chk("R9 done", done_cnt, 1);
        chk("R9 busy low", busy_seen, 0);
        chk("R9 no writes", ev_n - b, 0);
        chk("R9 no err", err_seen, 0);
    endtask

    task automatic t_bad_req();
        int b = ev_n;
        run_req(3'b111);
        chk("R10 err req", err_seen, 1);
        chk("R10 done req", done_cnt, 1);
        chk("R10 no writes req", ev_n - b, 0);
        chk("R10 mode kept", int'(mode_reg), 0);
    endtask

    task automatic t_bad_cur();
        int b;
        @(negedge clk); poke = 1'b1; poke_val = 3'b110;
        @(negedge clk); poke = 1'b0;
        b = ev_n;
        run_req(3'b001);
        chk("R10 err cur", err_seen, 1);
        chk("R10 no writes cur", ev_n - b, 0);
        chk("R10 mctl kept", int'(mctl_reg), mval(0, 1));
        @(negedge clk); poke = 1'b1; poke_val = 3'b000;
        @(negedge clk); poke = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset busy", int'(busy), 0);
        chk("R11 reset done", int'(done), 0);
        chk("R10 reset err", int'(err), 0);
        chk("R7 reset mode_wr", int'(mode_wr), 0);
        chk("R6 reset mctl_wr", int'(mctl_wr), 0);
        t_up_1_2();
        t_down_2_1();
        t_same();
        t_split_1_8();
        t_down_8_6();
        t_split_6_1();
        t_bad_req();
        t_bad_cur();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule